// File: doc/BRIEF.md
# Multiprocessor Serial Address Filter

This block sits behind the receiver of a 9-bit multiprocessor serial link and decides which received frames the local node keeps. A frame whose ninth bit is 1 carries an address. A frame whose ninth bit is 0 carries data. Two software-written registers define which addresses the node answers to: a node address and an enable mask.

A received address is compared against two derived patterns, and a hit on either one selects the node.
- The individual pattern: every bit where the mask is 1 must equal the node address bit, and every bit where the mask is 0 is ignored.
- The group-call pattern: the bitwise OR of address and mask. Every 1 in that OR must also be 1 in the received byte, and its 0 bits are ignored.

Once the node is selected, data frames are accepted until an address frame arrives that the node does not match. When the filter is disabled, every frame is accepted.

Several nodes on one link can share overlapping patterns. A single address can therefore select a group of them, and setting a bit that one node needs at 0 drops that node from the group. After reset both registers are zero, so every address matches and the node behaves like a plain receiver once it has seen any address frame.

Top module: `serial_addr_filter`

## Requirements
- R1: During and straight after reset, `accept` and `selected` are 0, and the node address and mask registers are all zeros.
- R2: An address frame (`rx_bit9`=1) matches the individual pattern when `((rx_data ^ node_addr) & node_mask) == 0`. For example, address 0xE0 with mask 0xFA accepts 0xE4, and address 0xC0 with mask 0xF9 accepts 0xC6.
- R3: An address frame matches the group-call pattern when every bit set in `node_addr | node_mask` is also set in `rx_data`. For example, address 0xE0 with mask 0xFC accepts 0xFF.
- R4: With both registers at their reset value of zero, any address frame matches.
- R5: A matching address frame, with the filter enabled, sets `selected` and pulses `accept`. Both are visible on the clock edge that registers the frame.
- R6: An address frame that matches neither pattern, with the filter enabled, clears `selected` and gives no `accept`. For example, 0xE4 against address 0xE0 with mask 0xFC is rejected.
- R7: A data frame (`rx_bit9`=0) received while `selected` is 1, with the filter enabled, pulses `accept` and leaves `selected` unchanged.
- R8: A data frame received while `selected` is 0, with the filter enabled, gives no `accept`.
- R9: With `filt_en`=0, every frame pulses `accept` whatever its ninth bit, and `selected` keeps its value.
- R10: A register write in the same cycle as a frame takes effect from the next frame. The frame in that cycle is compared against the old register values.
- R11: `accept` is a one-cycle pulse and is 1 only in the cycle after a cycle with `rx_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | 1 = filter frames by address, 0 = accept all frames |
| addr_we | input | 1 | Write strobe for the node address register |
| addr_wdata | input | W | Node address write value |
| mask_we | input | 1 | Write strobe for the enable mask register |
| mask_wdata | input | W | Enable mask write value |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_data | input | W | Received byte |
| rx_bit9 | input | 1 | Ninth bit of the frame (1 = address, 0 = data) |
| accept | output | 1 | Registered pulse: the frame is kept |
| selected | output | 1 | Node is currently addressed |

## Verification
The bench builds the block with the default width W=8. At that width the byte values worked out for the overlapping three-node group can be applied exactly as they are. These values cover an address that one node's pattern takes and another node's pattern rejects, a unique address for each node, and an all-ones group call. The short width also makes the reset-state case reachable, in which every register bit is a don't-care. It also lets the bench line up a register write and a frame in the same cycle with predictable values.

// File: rtl/serial_addr_filter.sv
module serial_addr_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         filt_en,
  input  logic         addr_we,
  input  logic [W-1:0] addr_wdata,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_bit9,
  output logic         accept,
  output logic         selected
);

  logic [W-1:0] node_addr, node_mask;

  wire [W-1:0] group_pat  = node_addr | node_mask;
  wire         indiv_hit  = ~|((rx_data ^ node_addr) & node_mask);
  wire         group_hit  = ~|(group_pat & ~rx_data);
  wire         addr_hit   = indiv_hit | group_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_addr <= '0;
      node_mask <= '0;
    end else begin
      if (addr_we) node_addr <= addr_wdata;
      if (mask_we) node_mask <= mask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept   <= 1'b0;
      selected <= 1'b0;
    end else begin
      accept <= 1'b0;
      if (rx_valid) begin
        if (!filt_en) begin
          accept <= 1'b1;
        end else if (rx_bit9) begin
          accept   <= addr_hit;
          selected <= addr_hit;
        end else begin
          accept <= selected;
        end
      end
    end
  end

  a_r11_accept_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(rx_valid));

  a_r6_miss_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filt_en && rx_bit9 && !indiv_hit && !group_hit) |=> (!selected && !accept));

  a_r5_hit_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filt_en && rx_bit9 && (indiv_hit || group_hit)) |=> (selected && accept));

  a_r7_data_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filt_en && !rx_bit9 && selected) |=> (accept && selected));

  a_r8_data_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filt_en && !rx_bit9 && !selected) |=> (!accept && !selected));

  a_r9_bypass_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !filt_en) |=> (accept && $stable(selected)));

endmodule

// File: tb/tb_serial_addr_filter.sv
module tb_serial_addr_filter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic filt_en = 1'b1;
  logic addr_we = 1'b0, mask_we = 1'b0, rx_valid = 1'b0, rx_bit9 = 1'b0;
  logic [W-1:0] addr_wdata = '0, mask_wdata = '0, rx_data = '0;
  logic accept, selected;

  always #10 clk = ~clk;

  serial_addr_filter #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .accept(accept), .selected(selected));

  typedef struct {
    logic  acc;
    logic  sel;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0, n_bad = 0;
  logic [W-1:0] m_addr = '0, m_mask = '0;
  logic m_sel = 1'b0;
  bit done = 0;

  task automatic cycle(input logic v, input logic [W-1:0] d, input logic b9,
                       input logic wa, input logic [W-1:0] va,
                       input logic wm, input logic [W-1:0] vm, input string tag);
    logic hit, acc;
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_bit9 = b9;
    addr_we = wa; addr_wdata = va; mask_we = wm; mask_wdata = vm;
    hit = (((d ^ m_addr) & m_mask) == '0) || (((m_addr | m_mask) & ~d) == '0);
    acc = 1'b0;
    if (v) begin
      if (!filt_en) acc = 1'b1;
      else if (b9) begin acc = hit; m_sel = hit; end
      else acc = m_sel;
    end
    if (wa) m_addr = va;
    if (wm) m_mask = vm;
    exp_q.push_back('{acc, m_sel, tag});
    @(negedge clk);
    rx_valid = 1'b0; addr_we = 1'b0; mask_we = 1'b0;
  endtask

  task automatic frame(input logic [W-1:0] d, input logic b9, input string tag);
    cycle(1'b1, d, b9, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic setregs(input logic [W-1:0] a, input logic [W-1:0] m);
    cycle(1'b0, '0, 1'b0, 1'b1, a, 1'b1, m, "R11");
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (accept !== e.acc || selected !== e.sel) begin
        n_bad++;
        $display("FAIL %s: accept/selected = %b/%b, expected %b/%b",
                 e.tag, accept, selected, e.acc, e.sel);
      end
    end else if (rst_n) begin
      n_vec++;
      if (accept !== 1'b0) begin
        n_bad++;
        $display("FAIL R11: idle accept = %b, expected 0", accept);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (accept !== 1'b0 || selected !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: accept/selected = %b/%b, expected 0/0", accept, selected);
    end
    rst_n = 1'b1;
    frame(8'h00, 1'b0, "R8");
    frame(8'h5A, 1'b1, "R4");
    frame(8'h33, 1'b0, "R7");
    setregs(8'hE0, 8'hFA);
    frame(8'hE4, 1'b1, "R2");
    frame(8'h11, 1'b0, "R7");
    setregs(8'hE0, 8'hFC);
    frame(8'hE4, 1'b1, "R6");
    frame(8'h22, 1'b0, "R8");
    frame(8'hFF, 1'b1, "R3");
    frame(8'hFC, 1'b1, "R3");
    frame(8'hE3, 1'b1, "R2");
    frame(8'hE7, 1'b1, "R6");
    setregs(8'hC0, 8'hF9);
    frame(8'hC6, 1'b1, "R2");
    frame(8'hC1, 1'b1, "R6");
    setregs(8'hE0, 8'hFA);
    cycle(1'b1, 8'hE4, 1'b1, 1'b0, '0, 1'b1, 8'hFF, "R10");
    frame(8'hE4, 1'b1, "R10");
    frame(8'h44, 1'b0, "R8");
    @(negedge clk); filt_en = 1'b0;
    frame(8'h44, 1'b0, "R9");
    frame(8'h01, 1'b1, "R9");
    @(negedge clk); filt_en = 1'b1;
    frame(8'hE0, 1'b1, "R5");
    @(negedge clk); filt_en = 1'b0;
    frame(8'h02, 1'b1, "R9");
    @(negedge clk); filt_en = 1'b1;
    frame(8'h55, 1'b0, "R7");
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule